// File: doc/BRIEF.md
# Two-Dimensional Parity Error Corrector

This block protects a 64-bit word (by default) by arranging its bits as a square grid of N rows and N columns. It keeps one even-parity bit per row and one per column, 2N check bits in total, which is far cheaper than storing duplicate copies. The encoder path takes a data word and emits it together with its row and column check bits. The checker path takes a word that has been stored, along with its saved check bits, and recomputes both sets of parities. A single flipped data bit shows up as exactly one failing row and exactly one failing column. The bit at their crossing is inverted and the repaired word is returned.

Data bit index `r*N + c` sits at row `r`, column `c`. Each path is one registered stage with a valid/ready handshake on both sides. A word is taken on a rising edge where `*_in_valid` and `*_in_ready` are both high, and it appears on `*_out_*` with `*_out_valid` high from that edge onward. An output that is valid but not taken holds every output pin unchanged. Input ready is high whenever the stage is empty or its output is being taken in the same cycle, so a stage can pass one word per cycle under a steady stream. The status flags accompany `chk_out_data` and are meaningful only while `chk_out_valid` is high.

Top module: `xpar_codec`

## Requirements
- R1: While `rst_n` is low and just after it rises, `enc_out_valid` and `chk_out_valid` are 0, and `enc_in_ready` and `chk_in_ready` are 1.
- R2: Encoder row check bit `r` equals the XOR of data bits `r*N` through `r*N+N-1`, which is even parity over the row.
- R3: Encoder column check bit `c` equals the XOR of data bits `c`, `N+c`, `2N+c`, and so on up to `(N-1)N+c`, which is even parity over the column. The data word leaves the encoder unchanged.
- R4: A word accepted on a rising edge is presented with output valid high immediately after that edge, which is one cycle of latency in each path.
- R5: When output valid is high and output ready is low, the output data, check bits and flags hold steady on the next edge, and input ready is low. When output ready is high or the stage is empty, input ready is high.
- R6: When both recomputed parity sets match the stored check bits, `chk_out_data` equals the input word and all three flags are 0.
- R7: When exactly one row and exactly one column mismatch, the data bit at their crossing is inverted, `chk_out_corrected` is 1, and the other two flags are 0.
- R8: When exactly one check bit in total mismatches (one row and no column, or one column and no row), the data passes through unchanged and only `chk_out_check_error` is 1.
- R9: Any other nonzero mismatch pattern passes the data through unchanged and sets only `chk_out_uncorrectable`.
- R10: At most one of the three flags is 1 in any valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| enc_in_valid | input | 1 | Encoder input word present |
| enc_in_ready | output | 1 | Encoder can take a word |
| enc_in_data | input | N*N | Word to encode |
| enc_out_valid | output | 1 | Encoded word present |
| enc_out_ready | input | 1 | Downstream takes the encoded word |
| enc_out_data | output | N*N | Word passed through the encoder |
| enc_out_row_par | output | N | Row check bits |
| enc_out_col_par | output | N | Column check bits |
| chk_in_valid | input | 1 | Checker input present |
| chk_in_ready | output | 1 | Checker can take a word |
| chk_in_data | input | N*N | Stored word to check |
| chk_in_row_par | input | N | Stored row check bits |
| chk_in_col_par | input | N | Stored column check bits |
| chk_out_valid | output | 1 | Checked word present |
| chk_out_ready | input | 1 | Downstream takes the checked word |
| chk_out_data | output | N*N | Word after correction |
| chk_out_corrected | output | 1 | One data bit was repaired |
| chk_out_check_error | output | 1 | One stored check bit was wrong |
| chk_out_uncorrectable | output | 1 | Mismatch pattern cannot be repaired |

## Verification
The hardest case to reach is a pair of upsets whose syndrome looks almost correctable. Two flips in one column leave the column parities clean but fail two rows. A data flip paired with a row check flip fails one column and two rows. Neither pattern occurs in normal encoder-to-checker traffic. The bench reaches these cases by encoding a word, applying chosen masks to the data and check bits between the two paths, and expecting `uncorrectable` for both patterns. A stalled output followed by a second offered word covers the back-pressure rule.

// File: rtl/xpar_pkg.sv
package xpar_pkg;

  typedef struct packed {
    logic uncorrectable;
    logic check_error;
    logic corrected;
  } xpar_status_t;

  localparam xpar_status_t XPAR_CLEAN = '{uncorrectable: 1'b0, check_error: 1'b0, corrected: 1'b0};

endpackage

// File: rtl/xpar_parity_gen.sv
module xpar_parity_gen #(
  parameter int N = 8
) (
  input  logic [N*N-1:0] data,
  output logic [N-1:0]   row_par,
  output logic [N-1:0]   col_par
);

  for (genvar r = 0; r < N; r++) begin : g_row
    assign row_par[r] = ^data[r*N +: N];
  end

  for (genvar c = 0; c < N; c++) begin : g_col
    logic [N-1:0] column;
    for (genvar r = 0; r < N; r++) begin : g_bit
      assign column[r] = data[r*N + c];
    end
    assign col_par[c] = ^column;
  end

endmodule

// File: rtl/xpar_encoder.sv
module xpar_encoder #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*N-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*N-1:0] out_data,
  output logic [N-1:0]   out_row_par,
  output logic [N-1:0]   out_col_par
);

  logic [N-1:0] row_next;
  logic [N-1:0] col_next;
  logic         take;

  xpar_parity_gen #(.N(N)) gen_i (
    .data    (in_data),
    .row_par (row_next),
    .col_par (col_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_row_par <= '0;
      out_col_par <= '0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_data    <= in_data;
      out_row_par <= row_next;
      out_col_par <= col_next;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/xpar_checker.sv
module xpar_checker
  import xpar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*N-1:0] in_data,
  input  logic [N-1:0]   in_row_par,
  input  logic [N-1:0]   in_col_par,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*N-1:0] out_data,
  output xpar_status_t   out_status
);

  localparam int W = N * N;

  logic [N-1:0] row_calc, col_calc;
  logic [N-1:0] row_syn, col_syn;
  logic         row_any, col_any, row_one, col_one;
  logic [W-1:0] flip_mask;
  logic [W-1:0] data_next;
  xpar_status_t status_next;
  logic         take;

  xpar_parity_gen #(.N(N)) gen_i (
    .data    (in_data),
    .row_par (row_calc),
    .col_par (col_calc)
  );

  assign row_syn = row_calc ^ in_row_par;
  assign col_syn = col_calc ^ in_col_par;
  assign row_any = |row_syn;
  assign col_any = |col_syn;
  assign row_one = row_any && ((row_syn & (row_syn - 1'b1)) == '0);
  assign col_one = col_any && ((col_syn & (col_syn - 1'b1)) == '0);

  for (genvar r = 0; r < N; r++) begin : g_mr
    for (genvar c = 0; c < N; c++) begin : g_mc
      assign flip_mask[r*N + c] = row_syn[r] & col_syn[c];
    end
  end

  always_comb begin
    status_next = XPAR_CLEAN;
    data_next   = in_data;
    if (row_one && col_one) begin
      status_next.corrected = 1'b1;
      data_next             = in_data ^ flip_mask;
    end else if ((row_one && !col_any) || (col_one && !row_any)) begin
      status_next.check_error = 1'b1;
    end else if (row_any || col_any) begin
      status_next.uncorrectable = 1'b1;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_status <= XPAR_CLEAN;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_data   <= data_next;
      out_status <= status_next;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/xpar_codec.sv
module xpar_codec
  import xpar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enc_in_valid,
  output logic           enc_in_ready,
  input  logic [N*N-1:0] enc_in_data,
  output logic           enc_out_valid,
  input  logic           enc_out_ready,
  output logic [N*N-1:0] enc_out_data,
  output logic [N-1:0]   enc_out_row_par,
  output logic [N-1:0]   enc_out_col_par,
  input  logic           chk_in_valid,
  output logic           chk_in_ready,
  input  logic [N*N-1:0] chk_in_data,
  input  logic [N-1:0]   chk_in_row_par,
  input  logic [N-1:0]   chk_in_col_par,
  output logic           chk_out_valid,
  input  logic           chk_out_ready,
  output logic [N*N-1:0] chk_out_data,
  output logic           chk_out_corrected,
  output logic           chk_out_check_error,
  output logic           chk_out_uncorrectable
);

  xpar_status_t chk_status;

  xpar_encoder #(.N(N)) enc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (enc_in_valid),
    .in_ready    (enc_in_ready),
    .in_data     (enc_in_data),
    .out_valid   (enc_out_valid),
    .out_ready   (enc_out_ready),
    .out_data    (enc_out_data),
    .out_row_par (enc_out_row_par),
    .out_col_par (enc_out_col_par)
  );

  xpar_checker #(.N(N)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (chk_in_valid),
    .in_ready   (chk_in_ready),
    .in_data    (chk_in_data),
    .in_row_par (chk_in_row_par),
    .in_col_par (chk_in_col_par),
    .out_valid  (chk_out_valid),
    .out_ready  (chk_out_ready),
    .out_data   (chk_out_data),
    .out_status (chk_status)
  );

  assign chk_out_corrected     = chk_status.corrected;
  assign chk_out_check_error   = chk_status.check_error;
  assign chk_out_uncorrectable = chk_status.uncorrectable;

endmodule

// File: rtl/xpar_codec_sva.sv
module xpar_codec_sva #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enc_in_valid,
  input logic           enc_in_ready,
  input logic [N*N-1:0] enc_in_data,
  input logic           enc_out_valid,
  input logic           enc_out_ready,
  input logic [N*N-1:0] enc_out_data,
  input logic [N-1:0]   enc_out_row_par,
  input logic [N-1:0]   enc_out_col_par,
  input logic           chk_in_valid,
  input logic           chk_in_ready,
  input logic [N*N-1:0] chk_in_data,
  input logic [N-1:0]   chk_in_row_par,
  input logic [N-1:0]   chk_in_col_par,
  input logic           chk_out_valid,
  input logic           chk_out_ready,
  input logic [N*N-1:0] chk_out_data,
  input logic           chk_out_corrected,
  input logic           chk_out_check_error,
  input logic           chk_out_uncorrectable
);

  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !enc_out_valid && !chk_out_valid); // R1

  AST_ENC_ROW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> (^enc_out_row_par) == (^enc_out_data)); // R2

  AST_ENC_COL_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> (^enc_out_col_par) == (^enc_out_data)); // R3

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid && enc_in_ready |=> enc_out_valid && enc_out_data == $past(enc_in_data)); // R4

  AST_CHK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_in_valid && chk_in_ready |=> chk_out_valid); // R4

  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_data)
      && $stable(enc_out_row_par) && $stable(enc_out_col_par)); // R5

  AST_CHK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chk_out_valid && !chk_out_ready |=> chk_out_valid && $stable(chk_out_data)
      && $stable({chk_out_corrected, chk_out_check_error, chk_out_uncorrectable})); // R5

  AST_CHK_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_out_valid && !chk_out_ready |-> !chk_in_ready); // R5

  AST_PASS_UNLESS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    chk_in_valid && chk_in_ready |=> chk_out_corrected || chk_out_data == $past(chk_in_data)); // R9

  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_in_valid && chk_in_ready |=> !chk_out_corrected
      || $countones(chk_out_data ^ $past(chk_in_data)) == 1); // R7

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_out_valid |-> $onehot0({chk_out_corrected, chk_out_check_error, chk_out_uncorrectable})); // R10

endmodule

bind xpar_codec xpar_codec_sva #(.N(N)) sva_i (.*);

// File: tb/xpar_codec_tb_top.sv
module xpar_codec_tb_top;

  localparam int N = 8;
  localparam int W = N * N;
  localparam int NV = 9;

  // Flag codes: 0 clean, 1 corrected, 2 check_error, 3 uncorrectable
  localparam logic [W-1:0] V_DATA [NV] = '{
    64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0BAD_F00D,
    64'h0000_0000_0000_0000, 64'hA5A5_A5A5_5A5A_5A5A, 64'h1357_9BDF_2468_ACE0,
    64'h0F0F_F0F0_3C3C_C3C3, 64'h8000_0000_0000_0001, 64'h7777_1111_EEEE_2222};
  localparam logic [W-1:0] V_FD [NV] = '{
    64'h0, 64'h1, 64'h8000_0000_0000_0000, 64'h0000_0000_0800_0000, 64'h0,
    64'h0, 64'h0000_0000_0000_0201, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_0020};
  localparam logic [N-1:0] V_FR [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h20};
  localparam logic [N-1:0] V_FC [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00};
  localparam int V_EXP [NV] = '{0, 1, 1, 1, 2, 2, 3, 3, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_in_valid = 1'b0, enc_out_ready = 1'b1;
  logic [W-1:0] enc_in_data = '0;
  logic chk_in_valid = 1'b0, chk_out_ready = 1'b1;
  logic [W-1:0] chk_in_data = '0;
  logic [N-1:0] chk_in_row_par = '0, chk_in_col_par = '0;
  logic enc_in_ready, enc_out_valid, chk_in_ready, chk_out_valid;
  logic [W-1:0] enc_out_data, chk_out_data;
  logic [N-1:0] enc_out_row_par, enc_out_col_par;
  logic chk_out_corrected, chk_out_check_error, chk_out_uncorrectable;

  int n_checks = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  xpar_codec #(.N(N)) dut_i (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_rows(input logic [W-1:0] d);
    logic [N-1:0] p = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) p[r] ^= d[r*N + c];
    return p;
  endfunction

  function automatic logic [N-1:0] model_cols(input logic [W-1:0] d);
    logic [N-1:0] p = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) p[c] ^= d[r*N + c];
    return p;
  endfunction

  function automatic logic [2:0] flags_for(input int code);
    case (code)
      1: return 3'b100;
      2: return 3'b010;
      3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  initial begin
    #(5 * 20000);
    n_err++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] saved_d;
    logic [N-1:0] saved_r, saved_c;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 enc_out_valid", W'(enc_out_valid), '0);
    check("R1 chk_out_valid", W'(chk_out_valid), '0);
    check("R1 ready", W'({enc_in_ready, chk_in_ready}), W'(2'b11));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", W'({enc_out_valid, chk_out_valid, enc_in_ready, chk_in_ready}), W'(4'b0011));

    for (int i = 0; i < NV; i++) begin
      enc_in_data  = V_DATA[i];
      enc_in_valid = 1'b1;
      @(negedge clk);
      enc_in_valid = 1'b0;
      check("R4 enc valid", W'(enc_out_valid), W'(1'b1));
      check("R2 row parity", W'(enc_out_row_par), W'(model_rows(V_DATA[i])));
      check("R3 col parity", W'(enc_out_col_par), W'(model_cols(V_DATA[i])));
      check("R3 enc data", enc_out_data, V_DATA[i]);
      chk_in_data    = enc_out_data ^ V_FD[i];
      chk_in_row_par = enc_out_row_par ^ V_FR[i];
      chk_in_col_par = enc_out_col_par ^ V_FC[i];
      chk_in_valid   = 1'b1;
      @(negedge clk);
      chk_in_valid = 1'b0;
      check("R4 chk valid", W'(chk_out_valid), W'(1'b1));
      check(V_EXP[i] == 1 ? "R7 data" : (V_EXP[i] == 0 ? "R6 data" : "R8/R9 data"),
            chk_out_data, (V_EXP[i] == 1) ? V_DATA[i] : (V_DATA[i] ^ V_FD[i]));
      check(V_EXP[i] == 0 ? "R6 flags" : (V_EXP[i] == 1 ? "R7 flags" :
            (V_EXP[i] == 2 ? "R8 flags" : "R9 flags R10")),
            W'({chk_out_corrected, chk_out_check_error, chk_out_uncorrectable}),
            W'(flags_for(V_EXP[i])));
    end

    // R5: back-pressure on the checker holds the first word, blocks the second
    @(negedge clk);
    chk_out_ready  = 1'b0;
    chk_in_data    = 64'hCAFE_0000_0000_1234 ^ 64'h4;
    chk_in_row_par = model_rows(64'hCAFE_0000_0000_1234);
    chk_in_col_par = model_cols(64'hCAFE_0000_0000_1234);
    chk_in_valid   = 1'b1;
    @(negedge clk);
    check("R5 not ready while stalled", W'(chk_in_ready), '0);
    chk_in_data    = 64'h0000_1111_2222_3333;
    chk_in_row_par = model_rows(64'h0000_1111_2222_3333);
    chk_in_col_par = model_cols(64'h0000_1111_2222_3333);
    repeat (2) @(negedge clk);
    check("R5 held data", chk_out_data, 64'hCAFE_0000_0000_1234);
    check("R5 held flag", W'(chk_out_corrected), W'(1'b1));
    chk_out_ready = 1'b1;
    @(negedge clk);
    chk_in_valid = 1'b0;
    check("R5 next word", chk_out_data, 64'h0000_1111_2222_3333);
    check("R6 next flags", W'({chk_out_corrected, chk_out_check_error, chk_out_uncorrectable}), '0);
    @(negedge clk);
    check("R5 drained", W'(chk_out_valid), '0);

    // R5: encoder stall keeps its parity outputs
    enc_out_ready = 1'b0;
    enc_in_data   = 64'h0000_0000_0000_00FF;
    enc_in_valid  = 1'b1;
    @(negedge clk);
    enc_in_data = 64'h1;
    @(negedge clk);
    enc_in_valid = 1'b0;
    check("R5 enc held data", enc_out_data, 64'hFF);
    check("R5 enc held rows", W'(enc_out_row_par), W'(model_rows(64'hFF)));
    check("R5 enc in_ready low", W'(enc_in_ready), '0);
    enc_out_ready = 1'b1;
    @(negedge clk);

    // R1: reset mid-stream clears the stages
    chk_in_valid = 1'b1;
    @(negedge clk);
    chk_in_valid = 1'b0;
    chk_out_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears valid", W'(chk_out_valid), '0);
    rst_n = 1'b1;
    chk_out_ready = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule